// File: doc/BRIEF.md
# DRAM Bank State Guard

This block watches the decoded command stream headed for a four-bank DRAM device and keeps a model of which banks hold an open row and which row that is. Every cycle in which clock enable is high, the command is judged against that model and against the read or write burst still in flight. A command that breaks a rule is not applied to the model, and a registered flag with a reason code reports it one cycle later.

Bursts are tracked by a down counter that is loaded with half the programmed burst length, since two data words move per clock. The counter drives the auto-precharge close, the read-to-write turnaround rule and the clock-enable rule. A second counter covers the refresh period, during which clock enable must also stay high. Minimum timing between commands is not checked.

Top module: `dram_bank_guard`

## Requirements
- R1: After reset all banks are closed, all open-row values are zero, `illegal_o` is low and `reason_o` is 0.
- R2: An ACTIVE command (code 1) to a closed bank opens it. From the next cycle its `bank_open_o` bit is set and its row field in `open_row_o` (bank i at bits i*ROW_W and up) holds `row_i`.
- R3: An ACTIVE command to a bank that is already open is flagged with reason 1, and the stored row does not change. This also holds in the cycle in which an auto-precharge close of that bank takes effect.
- R4: A READ (code 2) or WRITE (code 3) to a closed bank is flagged with reason 2 and starts no burst.
- R5: A legal READ or WRITE starts a burst that lasts BURST_LEN/2 cycles after the command. A cycle with `cke_i` low inside that window is flagged with reason 6. A cycle with `cke_i` low after the window is not flagged.
- R6: A READ or WRITE with `ap_i` set closes its bank at the clock edge that ends the burst, which is BURST_LEN/2 edges after the command.
- R7: A READ or WRITE issued while an auto-precharge burst is still running is flagged with reason 4.
- R8: A WRITE issued while a read burst is running is flagged with reason 3. A WRITE after BURST TERMINATE (code 6), or after the read burst has ended, is legal.
- R9: BURST TERMINATE ends a running read burst at once. If that burst had auto precharge, its bank closes at the same edge.
- R10: PRECHARGE (code 4) closes only the selected bank. PRECHARGE to a closed bank is legal and has no effect.
- R11: PRECHARGE ALL (code 5) closes every bank and cancels any running burst.
- R12: AUTO REFRESH (code 7) with any bank open is flagged with reason 5. A legal refresh starts a period of REF_CYC cycles in which `cke_i` low is flagged with reason 6.
- R13: While `cke_i` is low the command inputs are ignored and the bank state does not change.
- R14: `illegal_o` and `reason_o` are registered. They describe the command of the previous cycle, and they read 0 after a legal command or NOP (code 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable seen by the device |
| cmd_i | input | 3 | Command code: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 PRECHARGE ALL, 6 BURST TERMINATE, 7 AUTO REFRESH |
| bank_i | input | 2 | Target bank |
| row_i | input | ROW_W | Row address for ACTIVE |
| ap_i | input | 1 | Auto-precharge select for READ and WRITE |
| bank_open_o | output | 4 | One bit per bank, set while the bank has an open row |
| open_row_o | output | 4*ROW_W | Open row of each bank, bank i at bits i*ROW_W and up |
| illegal_o | output | 1 | Previous cycle's command broke a rule |
| reason_o | output | 3 | Reason: 0 none, 1 bank already open, 2 bank closed, 3 write during read burst, 4 auto precharge pending, 5 refresh with bank open, 6 clock enable dropped |

## Verification
An auto-precharge close and a new command to the same bank can land on the same clock edge. The bench provokes this with an ACTIVE to the bank in the last cycle of its auto-precharge read. It then expects reason 1, a closed bank and the old row, because the command must see the bank as still open. A BURST TERMINATE that ends an auto-precharge read is a second such meeting. There the bench checks that the bank closes at once and that a later drop of clock enable is not flagged.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PREA = 3'd5,
    CMD_BST  = 3'd6,
    CMD_REF  = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    RSN_NONE     = 3'd0,
    RSN_ACT_OPEN = 3'd1,
    RSN_CLOSED   = 3'd2,
    RSN_RD_WR    = 3'd3,
    RSN_AP_PEND  = 3'd4,
    RSN_REF_OPEN = 3'd5,
    RSN_CKE      = 3'd6
  } rsn_e;
endpackage

// File: rtl/dbg_down_cnt.sv
module dbg_down_cnt #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_o <= '0;
    else if (load_i)          cnt_o <= val_i;
    else if (clr_i)           cnt_o <= '0;
    else if (cnt_o != '0)     cnt_o <= cnt_o - W'(1);
  end

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !clr_i && cnt_o != '0) |=> (cnt_o == $past(cnt_o) - W'(1))); // R5
endmodule

// File: rtl/dbg_bank_table.sv
module dbg_bank_table #(
  parameter int NB    = 4,
  parameter int ROW_W = 13
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NB-1:0]       set_i,
  input  logic [NB-1:0]       clr_i,
  input  logic [ROW_W-1:0]    row_i,
  output logic [NB-1:0]       open_o,
  output logic [NB*ROW_W-1:0] rows_o
);
  for (genvar g = 0; g < NB; g++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_o[g]                  <= 1'b0;
        rows_o[g*ROW_W +: ROW_W]   <= '0;
      end else if (set_i[g]) begin
        open_o[g]                  <= 1'b1;
        rows_o[g*ROW_W +: ROW_W]   <= row_i;
      end else if (clr_i[g]) begin
        open_o[g]                  <= 1'b0;
      end
    end
  end

  AST_SET_CLR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i & clr_i) == '0); // R2
  AST_SET_ON_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i & open_o) == '0); // R3
endmodule

// File: rtl/dram_bank_guard.sv
module dram_bank_guard
  import dbg_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int BURST_LEN = 4,
  parameter int REF_CYC   = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cke_i,
  input  logic [2:0]                 cmd_i,
  input  logic [$clog2(NUM_BANKS)-1:0] bank_i,
  input  logic [ROW_W-1:0]           row_i,
  input  logic                       ap_i,
  output logic [NUM_BANKS-1:0]       bank_open_o,
  output logic [NUM_BANKS*ROW_W-1:0] open_row_o,
  output logic                       illegal_o,
  output logic [2:0]                 reason_o
);
  localparam int BA_W  = $clog2(NUM_BANKS);
  localparam int BHALF = BURST_LEN / 2;
  localparam int BW    = $clog2(BHALF + 1);
  localparam int RW    = $clog2(REF_CYC + 1);

  cmd_e cmd;
  assign cmd = cmd_e'(cmd_i);

  logic [BW-1:0]        bcnt;
  logic [RW-1:0]        rcnt;
  logic [BA_W-1:0]      bbank_q;
  logic                 bap_q, brd_q;
  logic                 b_load, b_clr, r_load, ill_d;
  rsn_e                 rsn_d, rsn_q;
  logic [NUM_BANKS-1:0] set_v, clr_v;
  logic                 burst_act;

  assign burst_act = (bcnt != '0);

  always_comb begin
    b_load = 1'b0;
    b_clr  = 1'b0;
    r_load = 1'b0;
    set_v  = '0;
    clr_v  = '0;
    ill_d  = 1'b0;
    rsn_d  = RSN_NONE;
    // auto-precharge close on the edge that ends the burst
    if (bcnt == BW'(1) && bap_q) clr_v[bbank_q] = 1'b1;
    if (!cke_i) begin
      if (burst_act || rcnt != '0) begin
        ill_d = 1'b1;
        rsn_d = RSN_CKE;
      end
    end else begin
      unique case (cmd)
        CMD_ACT: begin
          if (bank_open_o[bank_i]) begin
            ill_d = 1'b1;
            rsn_d = RSN_ACT_OPEN;
          end else begin
            set_v[bank_i] = 1'b1;
          end
        end
        CMD_RD, CMD_WR: begin
          if (burst_act && bap_q) begin
            ill_d = 1'b1;
            rsn_d = RSN_AP_PEND;
          end else if (!bank_open_o[bank_i]) begin
            ill_d = 1'b1;
            rsn_d = RSN_CLOSED;
          end else if (cmd == CMD_WR && burst_act && brd_q) begin
            ill_d = 1'b1;
            rsn_d = RSN_RD_WR;
          end else begin
            b_load = 1'b1;
          end
        end
        CMD_PRE: begin
          clr_v[bank_i] = 1'b1;
          if (burst_act && bbank_q == bank_i) b_clr = 1'b1;
        end
        CMD_PREA: begin
          clr_v = '1;
          b_clr = 1'b1;
        end
        CMD_BST: begin
          if (burst_act && brd_q) begin
            b_clr = 1'b1;
            if (bap_q) clr_v[bbank_q] = 1'b1;
          end
        end
        CMD_REF: begin
          if (|bank_open_o) begin
            ill_d = 1'b1;
            rsn_d = RSN_REF_OPEN;
          end else begin
            r_load = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bbank_q   <= '0;
      bap_q     <= 1'b0;
      brd_q     <= 1'b0;
      illegal_o <= 1'b0;
      rsn_q     <= RSN_NONE;
    end else begin
      if (b_load) begin
        bbank_q <= bank_i;
        bap_q   <= ap_i;
        brd_q   <= (cmd == CMD_RD);
      end
      illegal_o <= ill_d;
      rsn_q     <= rsn_d;
    end
  end
  assign reason_o = rsn_q;

  dbg_down_cnt #(.W(BW)) u_burst (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(b_load),
    .val_i (BW'(BHALF)), .clr_i(b_clr), .cnt_o(bcnt)
  );

  dbg_down_cnt #(.W(RW)) u_ref (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(r_load),
    .val_i (RW'(REF_CYC)), .clr_i(1'b0), .cnt_o(rcnt)
  );

  dbg_bank_table #(.NB(NUM_BANKS), .ROW_W(ROW_W)) u_banks (
    .clk_i (clk_i), .rst_ni(rst_ni), .set_i(set_v), .clr_i(clr_v),
    .row_i (row_i), .open_o(bank_open_o), .rows_o(open_row_o)
  );

  AST_ACT_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_i && cmd == CMD_ACT && !bank_open_o[bank_i]) |=> bank_open_o[$past(bank_i)]); // R2
  AST_ACT_OPEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_i && cmd == CMD_ACT && bank_open_o[bank_i])
      |=> (illegal_o && reason_o == RSN_ACT_OPEN && $stable(open_row_o))); // R3
  AST_RDWR_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_i && (cmd == CMD_RD || cmd == CMD_WR) && !bank_open_o[bank_i] && !(burst_act && bap_q))
      |=> (illegal_o && reason_o == RSN_CLOSED)); // R4
  AST_CKE_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_i && burst_act) |=> (illegal_o && reason_o == RSN_CKE)); // R5
  AST_PREA_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_i && cmd == CMD_PREA) |=> (bank_open_o == '0)); // R11
  AST_REF_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_i && cmd == CMD_REF && |bank_open_o) |=> (illegal_o && reason_o == RSN_REF_OPEN)); // R12
  AST_CKE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_i && !burst_act && rcnt == '0) |=> (!illegal_o && $stable(bank_open_o))); // R13
endmodule

// File: tb/dram_bank_guard_test.sv
module dram_bank_guard_test;
  localparam int RW_T = 13;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cke_i = 1'b1;
  logic [2:0]        cmd_i = 3'd0;
  logic [1:0]        bank_i = 2'd0;
  logic [RW_T-1:0]   row_i = '0;
  logic              ap_i = 1'b0;
  logic [3:0]        bank_open_o;
  logic [4*RW_T-1:0] open_row_o;
  logic              illegal_o;
  logic [2:0]        reason_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dram_bank_guard uut (
    .clk_i(clk), .rst_ni(rst_ni), .cke_i(cke_i), .cmd_i(cmd_i), .bank_i(bank_i),
    .row_i(row_i), .ap_i(ap_i), .bank_open_o(bank_open_o), .open_row_o(open_row_o),
    .illegal_o(illegal_o), .reason_o(reason_o)
  );

  function automatic logic [31:0] row_of(input int i);
    return 32'(open_row_o[i*RW_T +: RW_T]);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [1:0] b, input logic [RW_T-1:0] r,
                       input logic ap, input logic ck);
    @(negedge clk);
    cmd_i = c; bank_i = b; row_i = r; ap_i = ap; cke_i = ck;
    @(posedge clk);
    #1;
  endtask

  task automatic nop(input logic ck);
    issue(3'd0, 2'd0, '0, 1'b0, ck);
  endtask

  task automatic chk_ill(input string tag, input logic ill, input logic [2:0] rsn);
    check({tag, " illegal"}, 32'(illegal_o), 32'(ill));
    check({tag, " reason"}, 32'(reason_o), 32'(rsn));
  endtask

  task automatic t_reset;
    check("R1 open", 32'(bank_open_o), 0);
    check("R1 rows", 32'(|open_row_o), 0);
    chk_ill("R1", 1'b0, 3'd0);
  endtask

  task automatic t_act;
    issue(3'd1, 2'd1, 13'h123, 1'b0, 1'b1);
    check("R2 open", 32'(bank_open_o), 32'b0010);
    check("R2 row", row_of(1), 32'h123);
    chk_ill("R14", 1'b0, 3'd0);
    issue(3'd1, 2'd1, 13'h055, 1'b0, 1'b1);
    chk_ill("R3", 1'b1, 3'd1);
    check("R3 row", row_of(1), 32'h123);
  endtask

  task automatic t_closed;
    issue(3'd2, 2'd2, '0, 1'b0, 1'b1);
    chk_ill("R4", 1'b1, 3'd2);
    nop(1'b0);
    chk_ill("R4 no burst", 1'b0, 3'd0);
    nop(1'b1);
  endtask

  task automatic t_burst;
    issue(3'd2, 2'd1, '0, 1'b0, 1'b1);
    chk_ill("R14 rd", 1'b0, 3'd0);
    nop(1'b0);
    chk_ill("R5 first", 1'b1, 3'd6);
    nop(1'b0);
    chk_ill("R5 second", 1'b1, 3'd6);
    nop(1'b0);
    chk_ill("R5 after", 1'b0, 3'd0);
    nop(1'b1);
  endtask

  task automatic t_rdwr;
    issue(3'd1, 2'd0, 13'd7, 1'b0, 1'b1);
    check("R2 open b0", 32'(bank_open_o), 32'b0011);
    issue(3'd2, 2'd0, '0, 1'b0, 1'b1);
    issue(3'd3, 2'd0, '0, 1'b0, 1'b1);
    chk_ill("R8 wr in rd", 1'b1, 3'd3);
    issue(3'd6, 2'd0, '0, 1'b0, 1'b1);
    chk_ill("R8 bst", 1'b0, 3'd0);
    issue(3'd3, 2'd1, '0, 1'b0, 1'b1);
    chk_ill("R8 wr after bst", 1'b0, 3'd0);
    nop(1'b1); nop(1'b1);
    issue(3'd2, 2'd0, '0, 1'b0, 1'b1);
    nop(1'b1); nop(1'b1);
    issue(3'd3, 2'd0, '0, 1'b0, 1'b1);
    chk_ill("R8 wr after end", 1'b0, 3'd0);
    nop(1'b1); nop(1'b1);
  endtask

  task automatic t_ap;
    issue(3'd2, 2'd0, '0, 1'b1, 1'b1);
    check("R6 open at cmd", 32'(bank_open_o[0]), 1);
    issue(3'd2, 2'd0, '0, 1'b0, 1'b1);
    chk_ill("R7", 1'b1, 3'd4);
    check("R6 open mid", 32'(bank_open_o[0]), 1);
    nop(1'b1);
    check("R6 closed", 32'(bank_open_o[0]), 0);
  endtask

  task automatic t_same_edge;
    issue(3'd1, 2'd0, 13'd9, 1'b0, 1'b1);
    issue(3'd2, 2'd0, '0, 1'b1, 1'b1);
    nop(1'b1);
    issue(3'd1, 2'd0, 13'h00A, 1'b0, 1'b1);
    chk_ill("R3 close edge", 1'b1, 3'd1);
    check("R6 close edge", 32'(bank_open_o[0]), 0);
    check("R3 row kept", row_of(0), 32'd9);
  endtask

  task automatic t_bst_ap;
    issue(3'd1, 2'd0, 13'd3, 1'b0, 1'b1);
    issue(3'd2, 2'd0, '0, 1'b1, 1'b1);
    issue(3'd6, 2'd0, '0, 1'b0, 1'b1);
    chk_ill("R9 bst", 1'b0, 3'd0);
    check("R9 closed", 32'(bank_open_o[0]), 0);
    nop(1'b0);
    chk_ill("R9 burst gone", 1'b0, 3'd0);
    nop(1'b1);
  endtask

  task automatic t_pre;
    issue(3'd1, 2'd2, 13'h20, 1'b0, 1'b1);
    issue(3'd1, 2'd3, 13'h30, 1'b0, 1'b1);
    check("R2 three open", 32'(bank_open_o), 32'b1110);
    issue(3'd4, 2'd2, '0, 1'b0, 1'b1);
    check("R10 pre one", 32'(bank_open_o), 32'b1010);
    issue(3'd4, 2'd2, '0, 1'b0, 1'b1);
    chk_ill("R10 pre closed", 1'b0, 3'd0);
    check("R10 unchanged", 32'(bank_open_o), 32'b1010);
  endtask

  task automatic t_ref;
    issue(3'd7, 2'd0, '0, 1'b0, 1'b1);
    chk_ill("R12 ref open", 1'b1, 3'd5);
    issue(3'd2, 2'd1, '0, 1'b0, 1'b1);
    issue(3'd5, 2'd0, '0, 1'b0, 1'b1);
    check("R11 all closed", 32'(bank_open_o), 0);
    nop(1'b0);
    chk_ill("R11 burst cancelled", 1'b0, 3'd0);
    nop(1'b1);
    issue(3'd7, 2'd0, '0, 1'b0, 1'b1);
    chk_ill("R12 ref ok", 1'b0, 3'd0);
    nop(1'b0);
    chk_ill("R12 cke in ref", 1'b1, 3'd6);
    nop(1'b1); nop(1'b1); nop(1'b1);
    nop(1'b0);
    chk_ill("R12 after ref", 1'b0, 3'd0);
    nop(1'b1);
  endtask

  task automatic t_cke;
    issue(3'd1, 2'd2, 13'd5, 1'b0, 1'b0);
    chk_ill("R13 act ignored", 1'b0, 3'd0);
    check("R13 still closed", 32'(bank_open_o), 0);
    nop(1'b1);
    check("R13 closed later", 32'(bank_open_o), 0);
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_ni = 1'b1;
    t_act();
    t_closed();
    t_burst();
    t_rdwr();
    t_ap();
    t_same_edge();
    t_bst_ap();
    t_pre();
    t_ref();
    t_cke();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule